// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block turns a fast module clock into the timing for a serial clock. It does not drive a second clock domain. It produces a one-cycle toggle enable, `sck_en`, at each serial-clock edge. It also keeps a registered level, `sck_level`, that flips on every enable, so SCK has a 50% duty cycle. Two strobes classify each enable: `sck_lead` for a low-to-high edge and `sck_trail` for a high-to-low edge. A shift engine uses these strobes to launch and sample data.

A single configuration word sets the division, and it has two laws:
- **Linear law:** an 8-bit value N gives a full SCK period of 2×(N+1) module cycles.
- **Power-of-two law:** a 4-bit exponent E gives a period of 2^E module cycles.

A select bit picks the law. The module clock must run at least twice as fast as the wanted SCK. The power-of-two law reaches rates below the slowest linear setting.

The shift engine reports a busy flag. While that flag is high, the active setting is frozen, so a divider change cannot cut a half period short. Dropping the bus enable clears the count and the level.

Top module: `spi_sck_divider`

## Requirements
- R1: When `cfg_word[12]` is 1, `cfg_word[7:0]` = N and `sck_en` pulses once every N+1 module cycles, so the SCK period is 2×(N+1).
- R2: When `cfg_word[12]` is 0 and `cfg_word[11:8]` = E ≥ 1, `sck_en` pulses once every 2^(E-1) cycles, so the SCK period is 2^E.
- R3: In power-of-two mode with E = 0, `sck_en` is high on every enabled cycle.
- R4: On an `sck_en` cycle, `sck_lead` is high if `sck_level` is currently 0, and `sck_trail` is high if it is 1. The two strobes are never high together, and neither appears without `sck_en`.
- R5: `sck_level` inverts in the cycle after each `sck_en` and otherwise keeps its value, which gives equal high and low times.
- R6: While `bus_en` is 0, no enable or strobe appears, and the count and level return to zero. After `bus_en` rises, the first `sck_en` comes in the H-th enabled cycle, where H is the half-period length.
- R7: A setting is captured on every clock edge where `eng_busy` is 0 and is used from the next cycle on. Changes to `cfg_word` while `eng_busy` is 1 do not alter the enable spacing. If a newly captured half period is shorter than the count already reached, the enable fires at once.
- R8: After reset, `sck_level` is 0, no strobe is high, and the active setting is a half period of one cycle.
- R9: The extremes hold: N = 255 gives 256 cycles between enables, and E = 15 gives 16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mod | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus enable; when low, the count and level are held at zero |
| eng_busy | input | 1 | Shift engine busy; freezes the active setting |
| cfg_word | input | 13 | [7:0] linear N, [11:8] exponent E, [12] selects linear law |
| sck_en | output | 1 | Serial-clock toggle enable, one cycle wide |
| sck_level | output | 1 | Current serial-clock level (idle 0) |
| sck_lead | output | 1 | Leading-edge strobe |
| sck_trail | output | 1 | Trailing-edge strobe |

## Verification
The hardest case to reach from the ports is a new setting that lands in the middle of a half period while the count is already past the new limit. The stimulus handles it in two steps:
1. It runs a long linear setting with `eng_busy` high and rewrites `cfg_word` to a short one, which checks that the spacing does not change.
2. It drops `eng_busy` partway through a half period, so the short setting is captured when the count is already beyond it.

A behavioural model in the bench tracks the count, the level and the captured setting and compares all four outputs on every cycle. The stimulus also covers both extreme divides, the pass-through exponent and a bus disable in the middle of a run.

// File: rtl/spi_sck_div_pkg.sv
package spi_sck_div_pkg;
  localparam int unsigned DEF_LIN_W = 8;
  localparam int unsigned DEF_EXP_W = 4;

  typedef enum logic {
    MODE_POW2 = 1'b0,
    MODE_LIN  = 1'b1
  } div_mode_e;
endpackage

// File: rtl/sckdiv_cfg_hold.sv
module sckdiv_cfg_hold
  import spi_sck_div_pkg::*;
#(
  parameter int unsigned LIN_W  = DEF_LIN_W,
  parameter int unsigned EXP_W  = DEF_EXP_W,
  parameter int unsigned HALF_W = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   eng_busy,
  input  logic [LIN_W+EXP_W:0]   cfg_word,
  output logic [HALF_W-1:0]      half_q
);
  localparam int unsigned SEL_BIT = LIN_W + EXP_W;

  div_mode_e         mode;
  logic [LIN_W-1:0]  lin_n;
  logic [EXP_W-1:0]  exp_e;
  logic [HALF_W-1:0] lin_half;
  logic [HALF_W-1:0] pow_half;
  logic [HALF_W-1:0] half_d;

  always_comb begin
    mode     = div_mode_e'(cfg_word[SEL_BIT]);
    lin_n    = cfg_word[LIN_W-1:0];
    exp_e    = cfg_word[SEL_BIT-1:LIN_W];
    lin_half = HALF_W'(lin_n) + HALF_W'(1);
    if (exp_e == '0) pow_half = HALF_W'(1);
    else             pow_half = HALF_W'(1) << (exp_e - EXP_W'(1));
    half_d   = (mode == MODE_LIN) ? lin_half : pow_half;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         half_q <= HALF_W'(1);
    else if (!eng_busy) half_q <= half_d;
  end

  // R7: setting frozen across any edge where the engine is busy
  a_r7_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |=> $stable(half_q));
  // R8: the half period is never zero
  a_r8_half_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    half_q != '0);
endmodule

// File: rtl/sckdiv_counter.sv
module sckdiv_counter #(
  parameter int unsigned HALF_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic [HALF_W-1:0] half_q,
  output logic              tick
);
  logic [HALF_W-1:0] cnt;

  assign tick = bus_en && (cnt >= (half_q - HALF_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!bus_en) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + HALF_W'(1);
  end

  // R6: count is cleared after a disabled cycle
  a_r6_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> (cnt == '0));
  // R1: after a tick the count starts over
  a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));
endmodule

// File: rtl/sckdiv_edge_gen.sv
module sckdiv_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_en,
  input  logic tick,
  output logic level,
  output logic lead,
  output logic trail
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level <= 1'b0;
    else if (!bus_en) level <= 1'b0;
    else if (tick)   level <= ~level;
  end

  assign lead  = tick & ~level;
  assign trail = tick &  level;

  // R5: level flips after every tick
  a_r5_level_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && tick) |=> (level != $past(level)));
  // R4: a leading strobe leaves the level high, a trailing one low
  a_r4_lead_high: assert property (@(posedge clk) disable iff (!rst_n)
    (lead && bus_en) |=> level);
  a_r4_trail_low: assert property (@(posedge clk) disable iff (!rst_n)
    trail |=> !level);
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
  import spi_sck_div_pkg::*;
#(
  parameter int unsigned LIN_W = DEF_LIN_W,
  parameter int unsigned EXP_W = DEF_EXP_W
) (
  input  logic                 clk_mod,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 eng_busy,
  input  logic [LIN_W+EXP_W:0] cfg_word,
  output logic                 sck_en,
  output logic                 sck_level,
  output logic                 sck_lead,
  output logic                 sck_trail
);
  localparam int unsigned EXP_MAX = (1 << EXP_W) - 1;
  localparam int unsigned HALF_W  = (LIN_W + 1 > EXP_MAX) ? LIN_W + 1 : EXP_MAX;

  logic [HALF_W-1:0] half_q;
  logic              tick;

  sckdiv_cfg_hold #(.LIN_W(LIN_W), .EXP_W(EXP_W), .HALF_W(HALF_W)) u_cfg (
    .clk      (clk_mod),
    .rst_n    (rst_n),
    .eng_busy (eng_busy),
    .cfg_word (cfg_word),
    .half_q   (half_q)
  );

  sckdiv_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk    (clk_mod),
    .rst_n  (rst_n),
    .bus_en (bus_en),
    .half_q (half_q),
    .tick   (tick)
  );

  sckdiv_edge_gen u_edge (
    .clk    (clk_mod),
    .rst_n  (rst_n),
    .bus_en (bus_en),
    .tick   (tick),
    .level  (sck_level),
    .lead   (sck_lead),
    .trail  (sck_trail)
  );

  assign sck_en = tick;

  // R6: disabled bus is silent
  a_r6_quiet: assert property (@(posedge clk_mod) disable iff (!rst_n)
    !bus_en |-> (!sck_en && !sck_lead && !sck_trail));
  // R4: strobes only with the enable, never both
  a_r4_strobe_gate: assert property (@(posedge clk_mod) disable iff (!rst_n)
    (sck_lead || sck_trail) |-> (sck_en && !(sck_lead && sck_trail)));
endmodule

// File: tb/spi_sck_divider_tb.sv
module spi_sck_divider_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_mod = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        eng_busy = 1'b0;
  logic [12:0] cfg_word = '0;
  logic        sck_en, sck_level, sck_lead, sck_trail;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_half = 1;
  int m_cnt = 0;
  int m_lvl = 0;

  always #(CLK_PERIOD/2) clk_mod = ~clk_mod;

  spi_sck_divider u_dut (
    .clk_mod(clk_mod), .rst_n(rst_n), .bus_en(bus_en), .eng_busy(eng_busy),
    .cfg_word(cfg_word), .sck_en(sck_en), .sck_level(sck_level),
    .sck_lead(sck_lead), .sck_trail(sck_trail)
  );

  function automatic logic [12:0] lin_cfg(int n);
    return {1'b1, 4'd0, 8'(n)};
  endfunction

  function automatic logic [12:0] pow_cfg(int e);
    return {1'b0, 4'(e), 8'd0};
  endfunction

  // half period from the requirement text (R1, R2, R3)
  function automatic int half_of(logic [12:0] w);
    if (w[12]) return int'(w[7:0]) + 1;
    if (w[11:8] == 4'd0) return 1;
    return 1 << (int'(w[11:8]) - 1);
  endfunction

  task automatic cycle(string tag);
    logic [3:0] expv, actv;
    bit t;
    #1;
    t = bus_en && (m_cnt >= m_half - 1);
    expv = {t, 1'(m_lvl), t && (m_lvl == 0), t && (m_lvl == 1)};
    actv = {sck_en, sck_level, sck_lead, sck_trail};
    n_checks++;
    if (actv !== expv) begin
      n_fail++;
      $display("FAIL %s en/lvl/lead/trail actual %b expected %b at %0t", tag, actv, expv, $time);
    end
    @(posedge clk_mod);
    if (!rst_n) begin
      m_half = 1; m_cnt = 0; m_lvl = 0;
    end else begin
      if (!bus_en) begin m_cnt = 0; m_lvl = 0; end
      else if (t) begin m_cnt = 0; m_lvl = 1 - m_lvl; end
      else m_cnt++;
      if (!eng_busy) m_half = half_of(cfg_word);
    end
    @(negedge clk_mod);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) cycle(tag);
  endtask

  initial begin
    @(negedge clk_mod);
    run(5, "R8");                       // reset state
    rst_n = 1'b1;
    run(3, "R8");
    cfg_word = lin_cfg(2);
    run(6, "R6");                       // bus off: silent
    bus_en = 1'b1;
    run(40, "R1");                      // N=2: every 3 cycles, R4/R5 strobes
    cfg_word = lin_cfg(0);
    run(20, "R1");
    cfg_word = pow_cfg(0);
    run(20, "R3");                      // every cycle
    cfg_word = pow_cfg(1);
    run(20, "R2");
    cfg_word = pow_cfg(3);
    run(60, "R2");
    cfg_word = lin_cfg(20);
    run(30, "R4");
    eng_busy = 1'b1;
    cfg_word = lin_cfg(3);              // ignored while busy
    run(50, "R7");
    cfg_word = lin_cfg(40);
    run(15, "R7");
    eng_busy = 1'b0;                    // shorter setting, count already past it
    cfg_word = lin_cfg(3);
    run(40, "R7");
    bus_en = 1'b0;                      // mid-run disable
    run(8, "R6");
    bus_en = 1'b1;
    run(30, "R6");
    cfg_word = lin_cfg(255);
    run(1100, "R9");
    cfg_word = pow_cfg(15);
    run(33000, "R9");
    cfg_word = pow_cfg(2);
    run(30, "R5");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_mod);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R8 watchdog actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule